// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog built from two cascaded down-counters. The first counter sets the timeout and is reloaded by a software kick or, if enabled, by an edge on an external trigger pin. When the first counter runs out, the block can pulse any of three interrupt-type event outputs. It then either asserts hardware reset at once, or starts the second counter. In that case reset asserts only when the second counter also runs out. A watchdog output pin pulses either when the first counter runs out or one cycle earlier. The early setting lets the pin be wired back to the trigger input so that the chip never reaches reset.

Software writes three registers through a simple write port: the first load value, the second load value and an option word. The block does nothing after its own reset until an option word is written with the arm bit set.

Top module: `wdog_two_stage`

## Requirements
- R1: After `rst_n` is released, all outputs are low and the block is disarmed. Kicks, trigger edges and register writes without the arm bit produce no output.
- R2: Register addresses are 0 for the first load value, 1 for the second load value and 2 for the option word. Writing the option word with bit 7 (arm) set while the block is disarmed loads counter one from the first load value. With load value L and the arm write on clock edge a, the timeout pulse is visible after edge a+L+1.
- R3: Option bits 0, 1 and 2 enable `sci_o`, `nmi_o` and `smi_o` respectively. On a timeout, each enabled output is high for exactly one cycle and each disabled output stays low.
- R4: With option bit 3 clear, `hw_rst_o` rises load2+1 cycles after the cycle in which the timeout pulse is visible.
- R5: With option bit 3 set, `hw_rst_o` rises in the same cycle as the timeout pulse, whatever the second load value is.
- R6: Once high, `hw_rst_o` stays high until `rst_n`. Kicks and trigger edges have no effect after that point.
- R7: A `kick` sampled high on edge e, while the block is armed and not yet in reset, reloads counter one, and the timeout then follows after edge e+L+1.
- R8: With option bit 6 set, an edge on `trig_in` reloads counter one. The edge is rising when option bit 4 is clear and falling when bit 4 is set. An edge that appears before clock edge t1 acts on edge t1+2.
- R9: With option bit 6 clear, edges on `trig_in` do not move the timeout.
- R10: With option bit 5 clear, `wdo_o` pulses in the same cycle as the timeout. With bit 5 set and L ≥ 1, `wdo_o` pulses one cycle before it.
- R11: A retrigger while counter two is running cancels the pending reset and restarts counter one from its load value.
- R12: In early mode, with the trigger enabled on rising edges, bit 3 clear, L ≥ 1, load2 ≥ 1 and `wdo_o` wired to `trig_in`, `hw_rst_o` never asserts.
- R13: A load value written while a counter is running does not change that count; it is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | CW | Register write data |
| kick | input | 1 | Software retrigger strobe |
| trig_in | input | 1 | External retrigger pin (asynchronous) |
| sci_o | output | 1 | Timeout event pulse, class A |
| nmi_o | output | 1 | Timeout event pulse, class B |
| smi_o | output | 1 | Timeout event pulse, class C |
| wdo_o | output | 1 | Watchdog output pin pulse |
| hw_rst_o | output | 1 | Sticky hardware reset request |

## Verification
The timeout path is driven by four kinds of retrigger: none, a software kick part-way through the count, a trigger-pin edge of each polarity, and the block's own output wired back to its input. Timeout cycles that match the first load value separate "no reload" from "reload", and a pulse that lands exactly L+1 cycles after the stimulus confirms the synchronizer latency. Runs with and without the immediate-reset bit, and a kick issued during stage two, tell the direct reset path apart from the delayed one and from the cancelled one. A load value rewritten mid-count shows whether new values wait for the next reload.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          kick,
  input  logic          trig_in,
  output logic          sci_o,
  output logic          nmi_o,
  output logic          smi_o,
  output logic          wdo_o,
  output logic          hw_rst_o
);
  localparam int OPT_W = 8;
  localparam int B_SCI = 0, B_NMI = 1, B_SMI = 2, B_NOW = 3;
  localparam int B_FALL = 4, B_EARLY = 5, B_TEN = 6, B_ARM = 7;

  typedef enum logic [1:0] {S_IDLE, S_RUN1, S_RUN2, S_TRIP} st_t;

  st_t              st_q;
  logic [CW-1:0]    ld1_q, ld2_q, cnt1_q, cnt2_q;
  logic [OPT_W-1:0] opt_q;
  logic [2:0]       sy_q;
  logic             sci_q, nmi_q, smi_q, wdo_q, rst_q;
  logic             idle;

  wire pin_rise = sy_q[1] & ~sy_q[2];
  wire pin_fall = ~sy_q[1] & sy_q[2];
  wire pin_hit  = opt_q[B_TEN] & (opt_q[B_FALL] ? pin_fall : pin_rise);
  wire retrig   = kick | pin_hit;
  wire arm_wr   = cfg_we && cfg_addr == 2'd2 && cfg_wdata[B_ARM];
  wire expire1  = st_q == S_RUN1 && !retrig && cnt1_q == '0;
  wire pre1     = st_q == S_RUN1 && !retrig && cnt1_q == CW'(1);
  wire expire2  = st_q == S_RUN2 && !retrig && cnt2_q == '0;

  assign idle = st_q == S_IDLE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ld1_q <= '0;
      ld2_q <= '0;
      opt_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: ld1_q <= cfg_wdata;
        2'd1: ld2_q <= cfg_wdata;
        2'd2: opt_q <= cfg_wdata[OPT_W-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy_q <= '0;
    else        sy_q <= {sy_q[1:0], trig_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt1_q <= '0;
      cnt2_q <= '0;
    end else begin
      case (st_q)
        S_IDLE:
          if (arm_wr) begin
            st_q   <= S_RUN1;
            cnt1_q <= ld1_q;
          end
        S_RUN1:
          if (retrig)        cnt1_q <= ld1_q;
          else if (expire1) begin
            if (opt_q[B_NOW]) st_q <= S_TRIP;
            else begin
              st_q   <= S_RUN2;
              cnt2_q <= ld2_q;
            end
          end else           cnt1_q <= cnt1_q - 1'b1;
        S_RUN2:
          if (retrig) begin
            st_q   <= S_RUN1;
            cnt1_q <= ld1_q;
          end else if (expire2) st_q <= S_TRIP;
          else                  cnt2_q <= cnt2_q - 1'b1;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sci_q <= 1'b0;
      nmi_q <= 1'b0;
      smi_q <= 1'b0;
      wdo_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      sci_q <= expire1 & opt_q[B_SCI];
      nmi_q <= expire1 & opt_q[B_NMI];
      smi_q <= expire1 & opt_q[B_SMI];
      wdo_q <= opt_q[B_EARLY] ? pre1 : expire1;
      if ((expire1 && opt_q[B_NOW]) || expire2) rst_q <= 1'b1;
    end

  assign sci_o    = sci_q;
  assign nmi_o    = nmi_q;
  assign smi_o    = smi_q;
  assign wdo_o    = wdo_q;
  assign hw_rst_o = rst_q;
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sci,
  input logic       nmi,
  input logic       smi,
  input logic       wdo,
  input logic       hw_rst,
  input logic       idle,
  input logic [7:0] opt
);
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) hw_rst |=> hw_rst); // R6
  AST_SCI_GATED: assert property (@(posedge clk) disable iff (!rst_n) sci |-> $past(opt[0])); // R3
  AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n) nmi |-> $past(opt[1])); // R3
  AST_SMI_GATED: assert property (@(posedge clk) disable iff (!rst_n) smi |-> $past(opt[2])); // R3
  AST_SCI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) sci |=> !sci); // R3
  AST_IMM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (sci || nmi || smi) && $past(opt[3]) |-> hw_rst); // R5
  AST_LATE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_rst) && !$past(opt[3]) |-> !(sci || nmi || smi)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !(sci || nmi || smi || wdo || hw_rst)); // R1
endmodule

bind wdog_two_stage wdog_two_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sci(sci_o), .nmi(nmi_o), .smi(smi_o),
  .wdo(wdo_o), .hw_rst(hw_rst_o), .idle(idle), .opt(opt_q)
);

// File: tb/tb_wdog_two_stage.sv
module tb_wdog_two_stage;
  localparam int CW = 16;
  localparam int O_SCI = 1, O_NMI = 2, O_SMI = 4, O_NOW = 8;
  localparam int O_FALL = 16, O_EARLY = 32, O_TEN = 64, O_ARM = 128;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, kick = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic trig_drv = 1'b0, fb = 1'b0;
  logic sci_o, nmi_o, smi_o, wdo_o, hw_rst_o;
  wire trig = fb ? wdo_o : trig_drv;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_two_stage #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .kick(kick), .trig_in(trig),
    .sci_o(sci_o), .nmi_o(nmi_o), .smi_o(smi_o), .wdo_o(wdo_o), .hw_rst_o(hw_rst_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int v);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = CW'(v);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    fb = 1'b0; kick = 1'b0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic setup(input int l1, input int l2, input int opts);
    do_reset();
    wr(0, l1);
    wr(1, l2);
    wr(2, opts | O_ARM);
  endtask

  task automatic t_reset_idle();
    bit seen = 1'b0;
    trig_drv = 1'b0;
    do_reset();
    chk({sci_o, nmi_o, smi_o, wdo_o, hw_rst_o} == 5'b0, "R1 reset outputs", int'({sci_o, nmi_o, smi_o, wdo_o, hw_rst_o}), 0);
    wr(0, 2);
    wr(1, 1);
    wr(2, O_SCI | O_NMI | O_SMI | O_NOW | O_TEN);
    for (int i = 0; i < 30; i++) begin
      kick = (i % 5 == 0);
      trig_drv = (i % 7 < 3);
      tick();
      seen |= sci_o | nmi_o | smi_o | wdo_o | hw_rst_o;
    end
    kick = 1'b0; trig_drv = 1'b0;
    chk(!seen, "R1 disarmed quiet", int'(seen), 0);
  endtask

  task automatic t_delayed();
    setup(5, 3, O_SCI | O_NMI);
    tick(5);
    chk(sci_o == 1'b0, "R2 no early timeout", int'(sci_o), 0);
    tick();
    chk(sci_o && nmi_o, "R2 timeout at L+1", int'({sci_o, nmi_o}), 3);
    chk(!smi_o, "R3 disabled event", int'(smi_o), 0);
    chk(wdo_o, "R10 wdo with timeout", int'(wdo_o), 1);
    tick();
    chk(!sci_o && !wdo_o, "R3 single cycle", int'({sci_o, wdo_o}), 0);
    tick(2);
    chk(!hw_rst_o, "R4 reset not yet", int'(hw_rst_o), 0);
    tick();
    chk(hw_rst_o, "R4 delayed reset", int'(hw_rst_o), 1);
    kick = 1'b1;
    tick(10);
    kick = 1'b0;
    chk(hw_rst_o && !sci_o, "R6 reset sticky", int'({hw_rst_o, sci_o}), 2);
  endtask

  task automatic t_immediate();
    setup(4, 20, O_SMI | O_NOW);
    tick(4);
    chk(!hw_rst_o, "R5 reset before timeout", int'(hw_rst_o), 0);
    tick();
    chk(smi_o && hw_rst_o && !sci_o && !nmi_o, "R5 immediate reset",
        int'({smi_o, hw_rst_o, sci_o, nmi_o}), 12);
  endtask

  task automatic t_kick();
    bit seen = 1'b0;
    setup(6, 5, O_SCI);
    tick(3);
    kick = 1'b1; tick(); kick = 1'b0;
    for (int i = 0; i < 6; i++) begin tick(); seen |= sci_o; end
    chk(!seen, "R7 kick postpones", int'(seen), 0);
    tick();
    chk(sci_o, "R7 timeout after kick", int'(sci_o), 1);
  endtask

  task automatic t_cancel();
    setup(3, 6, O_SCI);
    tick(4);
    chk(sci_o, "R11 first timeout", int'(sci_o), 1);
    kick = 1'b1; tick(); kick = 1'b0;
    tick(3);
    chk(!sci_o, "R11 restart count", int'(sci_o), 0);
    tick();
    chk(sci_o && !hw_rst_o, "R11 second timeout", int'({sci_o, hw_rst_o}), 2);
    tick(3);
    chk(!hw_rst_o, "R11 pending reset cancelled", int'(hw_rst_o), 0);
  endtask

  task automatic t_pin(input bit fall, input bit en);
    bit seen = 1'b0;
    trig_drv = fall;
    setup(10, 5, O_SCI | (en ? O_TEN : 0) | (fall ? O_FALL : 0));
    tick(2);
    trig_drv = ~fall;
    if (en) begin
      for (int i = 0; i < 13; i++) begin tick(); seen |= sci_o; end
      chk(!seen, fall ? "R8 falling edge postpones" : "R8 rising edge postpones", int'(seen), 0);
      tick();
      chk(sci_o, fall ? "R8 falling edge timing" : "R8 rising edge timing", int'(sci_o), 1);
    end else begin
      tick(9);
      chk(sci_o, "R9 disabled pin ignored", int'(sci_o), 1);
    end
    trig_drv = 1'b0;
  endtask

  task automatic t_early_fb();
    bit seen_rst = 1'b0;
    int pulses = 0;
    trig_drv = 1'b0;
    setup(5, 4, O_SCI | O_EARLY | O_TEN);
    fb = 1'b1;
    tick(5);
    chk(wdo_o && !sci_o, "R10 early wdo", int'({wdo_o, sci_o}), 2);
    tick();
    chk(sci_o && !wdo_o, "R10 timeout after early wdo", int'({sci_o, wdo_o}), 2);
    for (int i = 0; i < 150; i++) begin
      tick();
      seen_rst |= hw_rst_o;
      pulses += int'(sci_o);
    end
    chk(!seen_rst, "R12 feedback avoids reset", int'(seen_rst), 0);
    chk(pulses >= 10, "R12 feedback keeps cycling", pulses, 10);
    fb = 1'b0;
  endtask

  task automatic t_reload_value();
    bit seen = 1'b0;
    setup(5, 10, O_SCI);
    tick();
    wr(0, 9);
    tick(3);
    chk(!sci_o, "R13 old value still counting", int'(sci_o), 0);
    tick();
    chk(sci_o, "R13 old value used", int'(sci_o), 1);
    kick = 1'b1; tick(); kick = 1'b0;
    for (int i = 0; i < 9; i++) begin tick(); seen |= sci_o; end
    chk(!seen, "R13 new value postpones", int'(seen), 0);
    tick();
    chk(sci_o, "R13 new value at reload", int'(sci_o), 1);
  endtask

  initial begin
    tick();
    t_reset_idle();
    t_delayed();
    t_immediate();
    t_kick();
    t_cancel();
    t_pin(1'b0, 1'b1);
    t_pin(1'b1, 1'b1);
    t_pin(1'b0, 1'b0);
    t_early_fb();
    t_reload_value();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule